// File: doc/BRIEF.md
# Four-Channel Split-Phase PWM Timer

This block is a four-channel PWM timer behind a 32-bit register interface in the APB style. Each channel drives one output. The period is built from two phase lengths that are programmed separately. The active phase comes first and lasts the high-field count plus one ticks. The second phase follows and lasts the low-field count plus one ticks. Because neither phase can be shorter than one tick, the output never reaches 0% or 100% duty.

Each channel takes its ticks from one of two sources. The first is the bus clock, which gives one tick per cycle. The second is an external tick line. That line passes through a synchronizer and a rising-edge detector, so each of its rising edges becomes a one-cycle count enable. A per-channel park bit inverts the waveform, so the high-field phase drives the output low. A new reload value is taken only when a period ends. Clearing the enable stops the channel at once, and its output falls to zero.

The bus has no wait states and no back-pressure. A write is accepted in the access cycle, when `psel`, `penable` and `pwrite` are all high. Read data is driven combinationally while `psel` is high and `pwrite` is low. The PWM outputs are plain level signals.

Top module: `pwm_hilo_timer`

## Requirements
- R1: After reset, every register reads 0 and every `pwm_o` bit is 0.
- R2: Register map:
  - The enable register sits at 0x1C. Channel c runs from bit 3+4c, and only those bits are stored.
  - The control register of channel c sits at 0x20+16c. Bits 4:0 are stored and the upper bits read 0. Bit 2 turns the channel on. Bit 3 selects the bus clock when set, and the external tick when clear. Bit 4 is the park bit.
  - The reload register of channel c sits at 0x24+16c and stores all 32 bits. Bits 31:16 are the high field and bits 15:0 are the low field.
  - The count register of channel c sits at 0x28+16c and is read-only.
- R3: Writes to offsets outside the map change no register, and reads from them return 0.
- R4: With the bus clock selected and park clear, the output rises one cycle after the enable write. It is high for high field + 1 cycles, then low for low field + 1 cycles, and the period repeats.
- R5: With the park bit set, the waveform is inverted. The output is low for high field + 1 ticks, then high for low field + 1 ticks.
- R6: A reload value written while a channel runs takes effect only at the start of the next period. The current period finishes with the old lengths.
- R7: When a channel's enable bit or mode bit is clear, its output is 0 from the cycle after the write. The period in progress is abandoned, and the count reads 0.
- R8: With the external source selected, the counter moves exactly once for each rising edge of `ext_tick_i`, and holds between edges.
- R9: The count register returns the remaining count of the current phase. It starts at the field value and counts down to 0.
- R10: A channel whose enable bit is set but whose mode bit is clear stays idle, with its output at 0 and its count at 0.
- R11: Channels run independently. Activity on one channel does not alter another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_tick_i | input | 1 | External tick, asynchronous to `clk` |
| pwm_o | output | NUM_CH | Per-channel PWM outputs |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit phase fields and a two-stage synchronizer. It programs small field values so that whole periods, a reload that lands mid-period and an inverted waveform all fit within a few dozen cycles. Running channels 0 and 2 together shows that the channels do not disturb each other. Channel 3, on the external source with slow hand-driven pulses, shows the counter stepping once per edge and holding between edges.

// File: rtl/pwm_hilo_pkg.sv
package pwm_hilo_pkg;
  localparam int REG_W       = 32;
  localparam int OFS_ENABLE  = 'h1C;
  localparam int OFS_CH_BASE = 'h20;
  localparam int CH_STRIDE   = 'h10;
  localparam int SUB_CTRL    = 'h0;
  localparam int SUB_RELOAD  = 'h4;
  localparam int SUB_COUNT   = 'h8;
  localparam int CTRL_W      = 5;

  // control field: park(4) busclk(3) mode(2) spare(1:0)
  typedef struct packed {
    logic       park;
    logic       busclk;
    logic       mode;
    logic [1:0] spare;
  } ctrl_t;

  function automatic int en_bit(input int ch);
    return 3 + 4 * ch;
  endfunction

  function automatic int ch_ofs(input int ch, input int sub);
    return OFS_CH_BASE + CH_STRIDE * ch + sub;
  endfunction
endpackage

// File: rtl/pwm_tick_sync.sv
module pwm_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-1:0], async_i};
  end

  assign pulse_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/pwm_hilo_channel.sv
module pwm_hilo_channel #(
  parameter int PHASE_W = 16,
  localparam int RLD_W  = 2 * PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               park_i,
  input  logic [RLD_W-1:0]   reload_i,
  output logic [PHASE_W-1:0] cnt_o,
  output logic               started_o,
  output logic               pwm_o
);
  logic [PHASE_W-1:0] cnt_q, lo_shadow_q;
  logic               first_q, started_q;
  logic [PHASE_W-1:0] hi_fld, lo_fld;

  assign hi_fld = reload_i[RLD_W-1:PHASE_W];
  assign lo_fld = reload_i[PHASE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      lo_shadow_q <= '0;
      first_q     <= 1'b1;
      started_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q     <= '0;
      first_q   <= 1'b1;
      started_q <= 1'b0;
    end else if (!started_q) begin
      started_q   <= 1'b1;
      first_q     <= 1'b1;
      cnt_q       <= hi_fld;
      lo_shadow_q <= lo_fld;
    end else if (tick_i) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (first_q) begin
        first_q <= 1'b0;
        cnt_q   <= lo_shadow_q;
      end else begin
        // period boundary: fresh reload value taken here
        first_q     <= 1'b1;
        cnt_q       <= hi_fld;
        lo_shadow_q <= lo_fld;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign started_o = started_q;
  assign pwm_o     = run_i & started_q & (first_q ^ park_i);
endmodule

// File: rtl/pwm_hilo_timer.sv
module pwm_hilo_timer
  import pwm_hilo_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int PHASE_W     = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              ext_tick_i,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int RLD_W = 2 * PHASE_W;

  logic [NUM_CH-1:0]              en_q;
  ctrl_t [NUM_CH-1:0]             ctrl_q;
  logic [NUM_CH-1:0][RLD_W-1:0]   reload_q;
  logic [NUM_CH-1:0][PHASE_W-1:0] ch_cnt;
  logic [NUM_CH-1:0]              ch_run, ch_tick, ch_started;
  logic                           ext_pulse;
  logic                           wr_en, rd_en;

  assign wr_en = psel & penable & pwrite;
  assign rd_en = psel & ~pwrite;

  pwm_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_tick_i), .pulse_o(ext_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (paddr == ADDR_W'(OFS_ENABLE)) begin
        for (int c = 0; c < NUM_CH; c++) en_q[c] <= pwdata[en_bit(c)];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (paddr == ADDR_W'(ch_ofs(c, SUB_CTRL)))
          ctrl_q[c] <= ctrl_t'(pwdata[CTRL_W-1:0]);
        if (paddr == ADDR_W'(ch_ofs(c, SUB_RELOAD)))
          reload_q[c] <= pwdata[RLD_W-1:0];
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_en) begin
      if (paddr == ADDR_W'(OFS_ENABLE)) begin
        for (int c = 0; c < NUM_CH; c++) prdata[en_bit(c)] = en_q[c];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (paddr == ADDR_W'(ch_ofs(c, SUB_CTRL)))   prdata = 32'(ctrl_q[c]);
        if (paddr == ADDR_W'(ch_ofs(c, SUB_RELOAD))) prdata = 32'(reload_q[c]);
        if (paddr == ADDR_W'(ch_ofs(c, SUB_COUNT)))  prdata = 32'(ch_cnt[c]);
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_run[c]  = en_q[c] & ctrl_q[c].mode;
    assign ch_tick[c] = ctrl_q[c].busclk | ext_pulse;

    pwm_hilo_channel #(.PHASE_W(PHASE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run_i(ch_run[c]), .tick_i(ch_tick[c]),
      .park_i(ctrl_q[c].park), .reload_i(reload_q[c]),
      .cnt_o(ch_cnt[c]), .started_o(ch_started[c]), .pwm_o(pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_hilo_timer_chk.sv
module pwm_hilo_timer_chk #(
  parameter int NUM_CH  = 4,
  parameter int PHASE_W = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              run,
  input logic [NUM_CH-1:0]              tick,
  input logic [NUM_CH-1:0]              started,
  input logic [NUM_CH-1:0][PHASE_W-1:0] cnt,
  input logic                           ext_pulse,
  input logic [NUM_CH-1:0]              pwm_o
);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |=> !ext_pulse);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    assert_stopped_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> !pwm_o[i]);
    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |=> cnt[i] == '0);
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && started[i] && !tick[i]) |=> $stable(cnt[i]));
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && started[i] && tick[i] && cnt[i] != '0)
        |=> cnt[i] == PHASE_W'($past(cnt[i]) - 1'b1));
  end
endmodule

bind pwm_hilo_timer pwm_hilo_timer_chk #(.NUM_CH(NUM_CH), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ch_run), .tick(ch_tick), .started(ch_started),
  .cnt(ch_cnt), .ext_pulse(ext_pulse), .pwm_o(pwm_o)
);

// File: tb/tb_pwm_hilo_timer.sv
module tb_pwm_hilo_timer;
  localparam int NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]        paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              ext_tick_i = 1'b0;
  logic [NUM_CH-1:0] pwm_o;

  int n_checks = 0, n_fails = 0;
  int mon_ch = 0;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pwm_hilo_timer dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_tick_i(ext_tick_i), .pwm_o(pwm_o)
  );

  task automatic check(input longint act, input longint exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int addr, input logic [31:0] data);
    psel = 1'b1; pwrite = 1'b1; paddr = 8'(addr); pwdata = data;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input int addr, output logic [31:0] data);
    psel = 1'b1; pwrite = 1'b0; paddr = 8'(addr);
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    data = prdata;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_check(input int addr, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_rd(addr, d);
    check(d, exp, tag);
  endtask

  // driver: expected samples, one per cycle
  task automatic push_wave(input int hi, input int lo, input logic park,
                           input int periods, input string tag);
    for (int p = 0; p < periods; p++) begin
      for (int k = 0; k <= hi; k++) sb_q.push_back('{1'b1 ^ park, tag});
      for (int k = 0; k <= lo; k++) sb_q.push_back('{1'b0 ^ park, tag});
    end
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic ext_pulse_once();
    ext_tick_i = 1'b1;
    repeat (4) @(negedge clk);
    ext_tick_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(pwm_o[mon_ch], e.v, e.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pwm_o, 0, "R1 outputs");
    rd_check('h1C, 0, "R1 enable");
    rd_check('h20, 0, "R1 ctrl0");
    rd_check('h24, 0, "R1 reload0");
    rd_check('h28, 0, "R1 count0");

    // R2 register map
    bus_wr('h30, 32'hFFFF_FFE3);
    rd_check('h30, 32'h03, "R2 ctrl1 width");
    bus_wr('h34, 32'hA5A5_5A5A);
    rd_check('h34, 32'hA5A5_5A5A, "R2 reload1");
    bus_wr('h1C, 32'hFFFF_FFFF);
    rd_check('h1C, 32'h0000_8888, "R2 enable bits");
    bus_wr('h1C, 0);
    bus_wr('h30, 0);

    // R3 undefined offsets
    bus_wr('h10, 32'hFFFF_FFFF);
    bus_wr('h2C, 32'hFFFF_FFFF);
    bus_wr('h60, 32'hFFFF_FFFF);
    rd_check('h2C, 0, "R3 hole read");
    rd_check('h60, 0, "R3 beyond map read");
    rd_check('h1C, 0, "R3 enable untouched");
    rd_check('h20, 0, "R3 ctrl0 untouched");
    rd_check('h34, 32'hA5A5_5A5A, "R3 reload1 untouched");

    // R4 bus clock waveform, then R7 disable mid-period
    mon_ch = 0;
    bus_wr('h20, 32'h0C);
    bus_wr('h24, (32'd2 << 16) | 32'd3);
    bus_wr('h1C, 32'h8);
    push_wave(2, 3, 1'b0, 3, "R4 wave");
    drain();
    bus_wr('h1C, 0);
    check(pwm_o[0], 0, "R7 output cut");
    rd_check('h28, 0, "R7 count cleared");

    // R5 park inversion
    bus_wr('h20, 32'h1C);
    bus_wr('h24, (32'd1 << 16) | 32'd4);
    bus_wr('h1C, 32'h8);
    push_wave(1, 4, 1'b1, 2, "R5 park wave");
    drain();
    bus_wr('h1C, 0);
    check(pwm_o[0], 0, "R7 parked idle low");

    // R6 reload at period boundary
    bus_wr('h20, 32'h0C);
    bus_wr('h24, (32'd2 << 16) | 32'd3);
    bus_wr('h1C, 32'h8);
    push_wave(2, 3, 1'b0, 1, "R6 old period");
    push_wave(1, 1, 1'b0, 2, "R6 new period");
    bus_wr('h24, (32'd1 << 16) | 32'd1);
    drain();
    bus_wr('h1C, 0);

    // R10 mode bit clear keeps channel idle
    bus_wr('h40, 32'h08);
    bus_wr('h44, 32'h0001_0001);
    bus_wr('h1C, 32'h800);
    repeat (10) @(negedge clk);
    check(pwm_o[2], 0, "R10 output idle");
    rd_check('h48, 0, "R10 count idle");
    bus_wr('h1C, 0);

    // R11 two channels at once
    bus_wr('h20, 32'h0C);
    bus_wr('h24, 32'h0);
    bus_wr('h40, 32'h1C);
    bus_wr('h44, (32'd3 << 16) | 32'd1);
    mon_ch = 2;
    bus_wr('h1C, 32'h808);
    push_wave(3, 1, 1'b1, 3, "R11 ch2 beside ch0");
    drain();
    check(pwm_o[1], 0, "R11 ch1 quiet");
    check(pwm_o[3], 0, "R11 ch3 quiet");
    bus_wr('h1C, 0);

    // R8 / R9 external tick source
    bus_wr('h60 - 'h10, 32'h04);
    bus_wr('h54, (32'd3 << 16) | 32'd2);
    bus_wr('h1C, 32'h8000);
    repeat (5) @(negedge clk);
    rd_check('h58, 3, "R9 count at phase start");
    check(pwm_o[3], 1, "R8 holds without ticks");
    ext_pulse_once();
    rd_check('h58, 2, "R8 one step per edge");
    repeat (3) ext_pulse_once();
    rd_check('h58, 2, "R9 count in low phase");
    check(pwm_o[3], 0, "R8 low phase reached");
    bus_wr('h1C, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule